// File: doc/BRIEF.md
# Masked-Write General-Purpose I/O Port

This block is a general-purpose I/O port on a pipelined Wishbone slave bus. All of its state is seen through one 32-bit word. Inputs and outputs have fixed directions, set by parameters when the block is built. Reading the word returns the synchronized input pins in the upper sixteen bits and the driven output pins in the lower sixteen bits.

A write carries its own mask. Each bit of the upper half says whether the output bit sixteen places below it is to be updated. Software can therefore set, clear or load any group of outputs in one store, with no read-modify-write beforehand and no race against other writers of other bits.

Each input pin passes through a two-stage synchronizer. The synchronized value is compared with its copy from the previous cycle. When any bit differs, the block raises a one-cycle change pulse.

The bus side has one flow-control rule. A request is accepted when `wb_cyc` and `wb_stb` are both high on a clock edge. Because `wb_stall` is held low, every such request is accepted on that edge, so the master can issue one request per cycle. Each accepted request is acknowledged on the next clock. The acknowledge cannot be delayed, so the master must be able to take one acknowledge per cycle.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is held and on the first cycle after it, `pin_out`, `wb_ack`, `wb_dat_r` and `chg_irq` are all zero.
- R2: An accepted write with data D sets output bit k to D[k] when D[k+16] is 1. For k < NOUT, the new value appears on `pin_out` after the accepting clock edge.
- R3: Output bits whose mask bit D[k+16] is 0 keep their value on an accepted write.
- R4: Outputs change only on an accepted write. A strobe while `wb_cyc` is low is not a request: it gets no acknowledge and changes no output.
- R5: Every accepted request is acknowledged exactly one clock after it is accepted, including back-to-back requests. No acknowledge appears without a request, and `wb_stall` is always 0.
- R6: The acknowledge carries the register as it stood at the accepting edge. Bits 31:16 hold the synchronized inputs and bits 15:0 hold the outputs. Bits at input positions NIN and above, and at output positions NOUT and above, read as 0. Write data in the unused output positions is discarded.
- R7: A pin change set up before edge E1 is first returned by a read accepted at edge E3. Reads accepted at E1 and E2 still return the old value.
- R8: For the change in R7, `chg_irq` is high for exactly the one cycle after edge E3. A change on several pins at once gives a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wb_cyc | input | 1 | Bus cycle active |
| wb_stb | input | 1 | Request strobe |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_dat_w | input | 32 | Write word: mask in 31:16, values in 15:0 |
| wb_stall | output | 1 | Back-pressure, held at 0 |
| wb_ack | output | 1 | Acknowledge, one clock after acceptance |
| wb_dat_r | output | 32 | Register word: inputs in 31:16, outputs in 15:0 |
| pin_in | input | NIN | Asynchronous input pins |
| pin_out | output | NOUT | Output pins |
| chg_irq | output | 1 | One-cycle pulse on a synchronized input change |

## Verification
Masked writes are tried with several mask patterns:
- a full mask, which shows the values are loaded;
- a single bit set and then cleared, which shows neighbours are untouched;
- alternating masks, which show the bits are paired by position;
- an empty mask, which shows nothing changes.

Each write is also checked against the unused upper output positions. Back-to-back bursts that mix reads and writes show that the acknowledge data is the pre-request state. A strobe with the cycle signal low separates a true request from a stray strobe. Changing input pins while reading on each of the following edges locates the synchronizer latency and the single pulse of the change flag exactly.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int REG_W  = 32;
  localparam int HALF_W = REG_W / 2;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [REG_W-1:0]  word_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] sync_o,
  output logic         change_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;
  logic         change_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_q   <= '0;
      prev_q   <= '0;
      change_q <= 1'b0;
    end else begin
      meta_q   <= pin_i;
      sync_q   <= meta_q;
      prev_q   <= sync_q;
      change_q <= |(sync_q ^ prev_q);
    end
  end

  assign sync_o   = sync_q;
  assign change_o = change_q;
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
  import gpio_mask_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  word_t        wr_word,
  output logic [N-1:0] out_o
);
  logic [N-1:0] out_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        out_q[k] <= 1'b0;
      else if (wr_en && wr_word[k + HALF_W])
        out_q[k] <= wr_word[k];
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
  import gpio_mask_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cyc_i,
  input  logic  stb_i,
  input  logic  we_i,
  input  word_t cur_word,
  output logic  wr_en,
  output logic  stall_o,
  output logic  ack_o,
  output word_t dat_o
);
  logic  req;
  logic  ack_q;
  word_t dat_q;

  assign req     = cyc_i && stb_i;
  assign wr_en   = req && we_i;
  assign stall_o = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= req;
      if (req)
        dat_q <= cur_word;
    end
  end

  assign ack_o = ack_q;
  assign dat_o = dat_q;
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int NIN  = 10,
  parameter int NOUT = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wb_cyc,
  input  logic            wb_stb,
  input  logic            wb_we,
  input  logic [31:0]     wb_dat_w,
  output logic            wb_stall,
  output logic            wb_ack,
  output logic [31:0]     wb_dat_r,
  input  logic [NIN-1:0]  pin_in,
  output logic [NOUT-1:0] pin_out,
  output logic            chg_irq
);
  logic [NIN-1:0]  in_sync;
  logic [NOUT-1:0] out_cur;
  logic            wr_en;
  half_t           in_half, out_half;
  word_t           cur_word;

  gpio_in_sync #(.N(NIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_in),
    .sync_o(in_sync), .change_o(chg_irq)
  );

  gpio_out_bank #(.N(NOUT)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_word(wb_dat_w), .out_o(out_cur)
  );

  gpio_bus_port u_bus (
    .clk(clk), .rst_n(rst_n), .cyc_i(wb_cyc), .stb_i(wb_stb),
    .we_i(wb_we), .cur_word(cur_word), .wr_en(wr_en),
    .stall_o(wb_stall), .ack_o(wb_ack), .dat_o(wb_dat_r)
  );

  always_comb begin
    in_half  = '0;
    out_half = '0;
    in_half[NIN-1:0]   = in_sync;
    out_half[NOUT-1:0] = out_cur;
    cur_word = {in_half, out_half};
  end

  assign pin_out = out_cur;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int NIN  = 10,
  parameter int NOUT = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wb_cyc,
  input logic            wb_stb,
  input logic            wb_we,
  input logic [31:0]     wb_dat_w,
  input logic            wb_stall,
  input logic            wb_ack,
  input logic [NOUT-1:0] pin_out
);
  logic [NOUT-1:0] mask_w, val_w;
  assign mask_w = wb_dat_w[16 +: NOUT];
  assign val_w  = wb_dat_w[NOUT-1:0];

  // R5
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_stb) |=> wb_ack);

  // R5
  no_stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_cyc && wb_stb) |=> !wb_ack);

  // R5
  stall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_stall);

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_cyc && wb_stb && wb_we) |=> $stable(pin_out));

  // R2
  masked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_stb && wb_we) |=>
      ((pin_out & $past(mask_w)) == ($past(val_w) & $past(mask_w))));

  // R3
  unmasked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_stb && wb_we) |=>
      ((pin_out & ~$past(mask_w)) == ($past(pin_out) & ~$past(mask_w))));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.NIN(NIN), .NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
  .wb_we(wb_we), .wb_dat_w(wb_dat_w), .wb_stall(wb_stall),
  .wb_ack(wb_ack), .pin_out(pin_out)
);

// File: tb/gpio_mask_port_bench.sv
module gpio_mask_port_bench;
  localparam int NIN  = 10;
  localparam int NOUT = 12;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [31:0]     wb_dat_w = '0;
  logic            wb_stall, wb_ack, chg_irq;
  logic [31:0]     wb_dat_r;
  logic [NIN-1:0]  pin_in = '0;
  logic [NOUT-1:0] pin_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  logic [NOUT-1:0] mdl_out = '0;
  logic [NIN-1:0]  mdl_in = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mask_port #(.NIN(NIN), .NOUT(NOUT)) u_gpio_mask_port (
    .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
    .wb_we(wb_we), .wb_dat_w(wb_dat_w), .wb_stall(wb_stall),
    .wb_ack(wb_ack), .wb_dat_r(wb_dat_r), .pin_in(pin_in),
    .pin_out(pin_out), .chg_irq(chg_irq)
  );

  function automatic logic [31:0] cur_word();
    logic [31:0] w = '0;
    w[16 +: NIN]  = mdl_in;
    w[NOUT-1:0]   = mdl_out;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drives one request at a negedge, holds it over one posedge.
  task automatic req(input bit we, input logic [31:0] d, input logic [31:0] exp_data);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_dat_w = d;
    exp_q.push_back(exp_data);
    if (we)
      for (int k = 0; k < NOUT; k++)
        if (d[16 + k]) mdl_out[k] = d[k];
    @(negedge clk);
  endtask

  task automatic idle();
    wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0; wb_dat_w = '0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    req(1'b1, d, cur_word());
    idle();
    check("R2/R3 pin_out", {20'd0, pin_out}, {20'd0, mdl_out});
  endtask

  // Monitor: pops expected acknowledge data as acks appear (R5, R6).
  always @(negedge clk) begin
    if (rst_n) begin
      check("R5 stall", {31'd0, wb_stall}, 32'd0);
      if (wb_ack) begin
        if (exp_q.size() == 0) check("R5 stray ack", 32'd1, 32'd0);
        else check("R6 ack data", wb_dat_r, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 under reset
    check("R1 reset out", {20'd0, pin_out}, 32'd0);
    check("R1 reset ack/irq", {30'd0, wb_ack, chg_irq}, 32'd0);
    check("R1 reset dat", wb_dat_r, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {19'd0, pin_out, wb_ack}, 32'd0);
    check("R1 after reset dat", wb_dat_r, 32'd0);

    // R2: full mask load, including unused positions (R6 discards them)
    wr(32'hFFFF_A5C3);
    req(1'b0, 0, cur_word()); idle();        // R6 upper output bits read 0
    // R2/R3: set one bit, then clear it
    wr(32'h0001_0001 << 2);
    wr(32'h0004_0000);
    // R3: alternating masks
    wr(32'h5555_0000);
    wr(32'hAAAA_FFFF);
    // R3: empty mask changes nothing
    wr(32'h0000_FFFF);

    // R4: strobe with cycle low
    wb_cyc = 1'b0; wb_stb = 1'b1; wb_we = 1'b1; wb_dat_w = 32'hFFFF_0000;
    @(negedge clk);
    wb_stb = 1'b0;
    @(negedge clk);
    check("R4 no ack", {31'd0, wb_ack}, 32'd0);
    check("R4 out held", {20'd0, pin_out}, {20'd0, mdl_out});

    // R5/R6: back-to-back mixed burst, data is pre-request state
    req(1'b0, 0, cur_word());
    req(1'b1, 32'h0FFF_0123, cur_word());
    req(1'b0, 0, cur_word());
    req(1'b1, 32'h0F00_0000, cur_word());
    req(1'b0, 0, cur_word());
    idle();
    check("R2 burst out", {20'd0, pin_out}, {20'd0, mdl_out});

    // R7/R8: single pin change, reads at E1, E2, E3
    pin_in = 10'h001;
    req(1'b0, 0, cur_word());                // E1: old
    check("R8 irq after E1", {31'd0, chg_irq}, 32'd0);
    req(1'b0, 0, cur_word());                // E2: old
    check("R8 irq after E2", {31'd0, chg_irq}, 32'd0);
    mdl_in = pin_in;
    req(1'b0, 0, cur_word());                // E3: new (R7)
    check("R8 irq after E3", {31'd0, chg_irq}, 32'd1);
    idle();
    check("R8 irq after E4", {31'd0, chg_irq}, 32'd0);

    // R8: several pins at once, single pulse
    pin_in = 10'h3F0;
    @(negedge clk); @(negedge clk);
    check("R8 multi before", {31'd0, chg_irq}, 32'd0);
    @(negedge clk);
    check("R8 multi pulse", {31'd0, chg_irq}, 32'd1);
    @(negedge clk);
    check("R8 multi end", {31'd0, chg_irq}, 32'd0);
    mdl_in = pin_in;
    req(1'b0, 0, cur_word()); idle();        // R6/R7 settled inputs

    repeat (3) @(negedge clk);
    check("R5 queue drained", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule